// File: doc/BRIEF.md
# Transient Event Log Master

This block sits above an array of capture cells. Each cell watches one comparator output and measures how long a glitch lasted. A cell holds its result until it is serviced. The master visits the cells one after another in a fixed rotation. When it finds a cell holding a result, it copies the measured duration into a log record and stamps the record with the current time of day. It then sends the cell an acknowledge pulse, followed by a reset strobe, so the cell goes back to watching.

The calendar is kept inside the block. It counts seconds, minutes and hours, and also days and months using fixed month lengths. It moves forward once for every one-second tick on its input. A host reads the log one entry at a time through an address/data port and sees how many entries are present. A single clear strobe empties the log. When the log fills, the count stops rising and each further event overwrites the last slot.

Top module: `ev_log_master`

## Requirements
- R1: After reset the entry count is 0, no acknowledge or reset strobe is active, and the calendar reads month 1, day 1, 0 hours, 0 minutes, 0 seconds.
- R2: Each clock cycle with `sec_tick` high advances the second field. Seconds wrap at `SEC_PER_MIN` and carry into minutes, minutes wrap at `MIN_PER_HOUR` and carry into hours, and hours wrap at `HOUR_PER_DAY` and carry into the day.
- R3: Day carry follows fixed month lengths: 28 for month 2, 30 for months 4, 6, 9 and 11, and 31 for the rest. The day after the last day of a month is day 1 of the next month, and the day after month 12 day 31 is month 1 day 1.
- R4: Each serviced event produces one record. Its bit layout is: [7:0] duration low byte, [15:8] duration high byte, [21:16] second, [27:22] minute, [32:28] hour, [37:33] day, [41:38] month, and the channel index from bit 42 upward. The timestamp is the calendar value at the moment the record is written.
- R5: Servicing a cell raises its `cell_ack` bit for exactly one cycle, then its `cell_clr` bit for exactly the following cycle. At most one bit of each vector is high at any time.
- R6: Cells that are pending at the same time are logged as separate entries in cyclic ascending channel order, starting from wherever the rotation currently stands.
- R7: The entry count rises by one per stored event while it is below `LOG_DEPTH-1`. Once it equals `LOG_DEPTH-1` it stays there, and each new event overwrites slot `LOG_DEPTH-1`.
- R8: A `host_clear` pulse sets the entry count to 0 and leaves the calendar unchanged. The next event is stored in slot 0.
- R9: A cell whose valid input stays low receives no acknowledge or reset strobe and adds no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| cell_valid | input | NUM_CELLS | Cell holds a finished measurement |
| cell_dur | input | NUM_CELLS*16 | Per-cell duration, cell k at bits [16k+15:16k] |
| cell_ack | output | NUM_CELLS | One-cycle acknowledge to the serviced cell |
| cell_clr | output | NUM_CELLS | One-cycle reset strobe returning the cell to watch |
| host_clear | input | 1 | Empties the log |
| rd_addr | input | clog2(LOG_DEPTH) | Log slot to read |
| rd_data | output | clog2(NUM_CELLS)+42 | Record held in the addressed slot |
| entry_count | output | clog2(LOG_DEPTH) | Number of entries counted |

## Verification
The bench drives the calendar to the ends of January, February and December and reads the stamps logged just before and just after each boundary. A wrong month length, or a missing year wrap, would put a day 29 or day 32 or a month 13 into the log. It posts several cells in the same cycle and checks that each becomes its own entry in rotation order, with the duration bytes in the right place. A scanner that merged events or swapped the byte order would break those checks. It pushes more events than the log holds, and a counter that wrapped or kept rising would clobber slot 0 or report a count beyond capacity. After a clear it confirms that the stamps continue from the running time rather than from a reset calendar.

// File: rtl/ev_log_pkg.sv
package ev_log_pkg;

   localparam int SEC_W  = 6;
   localparam int MIN_W  = 6;
   localparam int HR_W   = 5;
   localparam int DAY_W  = 5;
   localparam int MON_W  = 4;
   localparam int DUR_W  = 16;
   localparam int BYTE_W = 8;

   typedef struct packed {
      logic [MON_W-1:0] mon;
      logic [DAY_W-1:0] day;
      logic [HR_W-1:0]  hr;
      logic [MIN_W-1:0] mins;
      logic [SEC_W-1:0] secs;
   } stamp_t;

   localparam int STAMP_W = $bits(stamp_t);

   typedef enum logic [1:0] {
      SC_LOOK  = 2'd0,
      SC_WRITE = 2'd1,
      SC_ACK   = 2'd2,
      SC_CLR   = 2'd3
   } scan_st_t;

   function automatic logic [DAY_W-1:0] days_in(input logic [MON_W-1:0] m);
      case (m)
         4'd2:                   days_in = 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11: days_in = 5'd30;
         default:                days_in = 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/ev_calendar.sv
module ev_calendar
   import ev_log_pkg::*;
#(
   parameter int SEC_PER_MIN  = 60,
   parameter int MIN_PER_HOUR = 60,
   parameter int HOUR_PER_DAY = 24
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   tick,
   output stamp_t now
);

   if (SEC_PER_MIN < 2 || SEC_PER_MIN > (1 << SEC_W)) begin : g_bad_spm
      $error("SEC_PER_MIN out of range");
   end
   if (MIN_PER_HOUR < 2 || MIN_PER_HOUR > (1 << MIN_W)) begin : g_bad_mph
      $error("MIN_PER_HOUR out of range");
   end
   if (HOUR_PER_DAY < 2 || HOUR_PER_DAY > (1 << HR_W)) begin : g_bad_hpd
      $error("HOUR_PER_DAY out of range");
   end

   localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
   localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_PER_HOUR - 1);
   localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(HOUR_PER_DAY - 1);

   logic sec_end, min_end, hr_end, day_end, mon_end;

   always_comb begin
      sec_end = (now.secs == SEC_LAST);
      min_end = (now.mins == MIN_LAST);
      hr_end  = (now.hr == HR_LAST);
      day_end = (now.day == days_in(now.mon));
      mon_end = (now.mon == MON_W'(12));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now.mon  <= MON_W'(1);
         now.day  <= DAY_W'(1);
         now.hr   <= '0;
         now.mins <= '0;
         now.secs <= '0;
      end else if (tick) begin
         if (!sec_end) begin
            now.secs <= now.secs + 1'b1;
         end else begin
            now.secs <= '0;
            if (!min_end) begin
               now.mins <= now.mins + 1'b1;
            end else begin
               now.mins <= '0;
               if (!hr_end) begin
                  now.hr <= now.hr + 1'b1;
               end else begin
                  now.hr <= '0;
                  if (!day_end) begin
                     now.day <= now.day + 1'b1;
                  end else begin
                     now.day <= DAY_W'(1);
                     now.mon <= mon_end ? MON_W'(1) : now.mon + 1'b1;
                  end
               end
            end
         end
      end
   end

   assert_sec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      now.secs <= SEC_LAST);

   assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !sec_end) |=> (now.secs == $past(now.secs) + 1'b1) && $stable(now.mins));

   assert_day_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (now.day >= DAY_W'(1)) && (now.day <= days_in(now.mon)) && (now.mon >= MON_W'(1)) && (now.mon <= MON_W'(12)));

   assert_year_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sec_end && min_end && hr_end && day_end && mon_end) |=> (now.mon == MON_W'(1)) && (now.day == DAY_W'(1)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(now));

endmodule

// File: rtl/ev_scanner.sv
module ev_scanner
   import ev_log_pkg::*;
#(
   parameter int NUM_CELLS = 4,
   parameter int CH_W      = $clog2(NUM_CELLS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CELLS-1:0]       cell_valid,
   input  logic [NUM_CELLS*DUR_W-1:0] cell_dur,
   output logic [NUM_CELLS-1:0]       cell_ack,
   output logic [NUM_CELLS-1:0]       cell_clr,
   output logic                       wr_en,
   output logic [CH_W-1:0]            wr_chan,
   output logic [DUR_W-1:0]           wr_dur
);

   localparam logic [CH_W-1:0] PTR_LAST = CH_W'(NUM_CELLS - 1);

   scan_st_t          st;
   logic [CH_W-1:0]   ptr;
   logic [CH_W-1:0]   ptr_nxt;
   logic [DUR_W-1:0]  cap_dur;
   logic [DUR_W-1:0]  dur_arr [NUM_CELLS];
   logic              hit;

   for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
      assign dur_arr[g]  = cell_dur[g*DUR_W +: DUR_W];
      assign cell_ack[g] = (st == SC_ACK) && (ptr == CH_W'(g));
      assign cell_clr[g] = (st == SC_CLR) && (ptr == CH_W'(g));
   end

   always_comb begin
      ptr_nxt = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
      hit     = cell_valid[ptr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SC_LOOK;
         ptr     <= '0;
         cap_dur <= '0;
      end else begin
         case (st)
            SC_LOOK: begin
               if (hit) begin
                  cap_dur <= dur_arr[ptr];
                  st      <= SC_WRITE;
               end else begin
                  ptr <= ptr_nxt;
               end
            end
            SC_WRITE: st <= SC_ACK;
            SC_ACK:   st <= SC_CLR;
            default: begin
               st  <= SC_LOOK;
               ptr <= ptr_nxt;
            end
         endcase
      end
   end

   assign wr_en   = (st == SC_WRITE);
   assign wr_chan = ptr;
   assign wr_dur  = cap_dur;

   assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cell_ack) && $onehot0(cell_clr) && ((cell_ack & cell_clr) == '0));

   assert_clr_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_ack != '0) |=> (cell_clr == $past(cell_ack)));

   assert_write_before_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cell_ack != '0));

   assert_idle_cell_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == SC_LOOK) && !hit) |=> (cell_ack == '0) && !wr_en);

endmodule

// File: rtl/ev_log_store.sv
module ev_log_store #(
   parameter int LOG_DEPTH = 8,
   parameter int REC_W     = 44,
   parameter int CNT_W     = $clog2(LOG_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REC_W-1:0] wr_rec,
   input  logic             clear,
   input  logic [CNT_W-1:0] rd_addr,
   output logic [REC_W-1:0] rd_data,
   output logic [CNT_W-1:0] count
);

   if (LOG_DEPTH < 2) begin : g_bad_depth
      $error("LOG_DEPTH must be at least 2");
   end

   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LOG_DEPTH - 1);

   logic [REC_W-1:0] mem [LOG_DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (wr_en && (count != CNT_TOP)) begin
         count <= count + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[count] <= wr_rec;
      end
   end

   if ((1 << CNT_W) == LOG_DEPTH) begin : g_rd_pow2
      assign rd_data = mem[rd_addr];
   end else begin : g_rd_guard
      assign rd_data = (rd_addr <= CNT_TOP) ? mem[rd_addr] : '0;
   end

   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_TOP);

   assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clear && (count != CNT_TOP)) |=> (count == $past(count) + 1'b1));

   assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clear && (count == CNT_TOP)) |=> (count == CNT_TOP));

   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0));

endmodule

// File: rtl/ev_log_master.sv
module ev_log_master
   import ev_log_pkg::*;
#(
   parameter int NUM_CELLS    = 4,
   parameter int LOG_DEPTH    = 8,
   parameter int SEC_PER_MIN  = 60,
   parameter int MIN_PER_HOUR = 60,
   parameter int HOUR_PER_DAY = 24,
   localparam int CH_W        = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
   localparam int CNT_W       = $clog2(LOG_DEPTH),
   localparam int REC_W       = CH_W + STAMP_W + DUR_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sec_tick,
   input  logic [NUM_CELLS-1:0]       cell_valid,
   input  logic [NUM_CELLS*DUR_W-1:0] cell_dur,
   output logic [NUM_CELLS-1:0]       cell_ack,
   output logic [NUM_CELLS-1:0]       cell_clr,
   input  logic                       host_clear,
   input  logic [CNT_W-1:0]           rd_addr,
   output logic [REC_W-1:0]           rd_data,
   output logic [CNT_W-1:0]           entry_count
);

   if (NUM_CELLS < 2) begin : g_bad_cells
      $error("NUM_CELLS must be at least 2");
   end

   stamp_t            now;
   logic              wr_en;
   logic [CH_W-1:0]   wr_chan;
   logic [DUR_W-1:0]  wr_dur;
   logic [REC_W-1:0]  wr_rec;

   ev_calendar #(
      .SEC_PER_MIN  (SEC_PER_MIN),
      .MIN_PER_HOUR (MIN_PER_HOUR),
      .HOUR_PER_DAY (HOUR_PER_DAY)
   ) u_cal (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (sec_tick),
      .now   (now)
   );

   ev_scanner #(
      .NUM_CELLS (NUM_CELLS),
      .CH_W      (CH_W)
   ) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .cell_valid (cell_valid),
      .cell_dur   (cell_dur),
      .cell_ack   (cell_ack),
      .cell_clr   (cell_clr),
      .wr_en      (wr_en),
      .wr_chan    (wr_chan),
      .wr_dur     (wr_dur)
   );

   assign wr_rec = {wr_chan, now, wr_dur[DUR_W-1 -: BYTE_W], wr_dur[BYTE_W-1:0]};

   ev_log_store #(
      .LOG_DEPTH (LOG_DEPTH),
      .REC_W     (REC_W),
      .CNT_W     (CNT_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_rec  (wr_rec),
      .clear   (host_clear),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .count   (entry_count)
   );

   assert_clear_keeps_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_clear && !sec_tick) |=> $stable(now));

endmodule

// File: tb/ev_log_master_bench.sv
module ev_log_master_bench;

   localparam int CLK_P = 10;
   localparam int NC    = 4;
   localparam int DP    = 4;
   localparam int SPM   = 3;
   localparam int MPH   = 2;
   localparam int HPD   = 2;
   localparam int CH_W  = 2;
   localparam int CNT_W = 2;
   localparam int RW    = CH_W + 42;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sec_tick = 1'b0;
   logic [NC-1:0]     cell_valid = '0;
   logic [NC*16-1:0]  cell_dur = '0;
   logic [NC-1:0]     cell_ack;
   logic [NC-1:0]     cell_clr;
   logic              host_clear = 1'b0;
   logic [CNT_W-1:0]  rd_addr = '0;
   logic [RW-1:0]     rd_data;
   logic [CNT_W-1:0]  entry_count;

   logic [NC-1:0]     post_req = '0;
   int checks = 0;
   int errors = 0;
   int served = 0;
   int ack_seen = 0;
   int hs_err = 0;
   int served_ch [16];
   logic [NC-1:0] prev_ack = '0;

   int m_mon = 1, m_day = 1, m_hr = 0, m_mi = 0, m_se = 0;

   always #(CLK_P/2) clk = ~clk;

   ev_log_master #(
      .NUM_CELLS    (NC),
      .LOG_DEPTH    (DP),
      .SEC_PER_MIN  (SPM),
      .MIN_PER_HOUR (MPH),
      .HOUR_PER_DAY (HPD)
   ) u_ev_log_master (
      .clk         (clk),
      .rst_n       (rst_n),
      .sec_tick    (sec_tick),
      .cell_valid  (cell_valid),
      .cell_dur    (cell_dur),
      .cell_ack    (cell_ack),
      .cell_clr    (cell_clr),
      .host_clear  (host_clear),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .entry_count (entry_count)
   );

   // cell model and handshake monitor
   always @(negedge clk) begin
      if (cell_clr != '0) begin
         for (int i = 0; i < NC; i++) if (cell_clr[i]) served_ch[served % 16] = i;
         served = served + 1;
         if (cell_clr != prev_ack) hs_err = hs_err + 1;
      end
      if (cell_ack != '0) ack_seen = ack_seen + 1;
      if ($countones(cell_ack) > 1 || $countones(cell_clr) > 1) hs_err = hs_err + 1;
      prev_ack = cell_ack;
      cell_valid = (cell_valid & ~cell_clr) | post_req;
   end

   function automatic int mlen(input int m);
      if (m == 2) return 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic model_tick();
      m_se++;
      if (m_se == SPM) begin
         m_se = 0; m_mi++;
         if (m_mi == MPH) begin
            m_mi = 0; m_hr++;
            if (m_hr == HPD) begin
               m_hr = 0; m_day++;
               if (m_day > mlen(m_mon)) begin
                  m_day = 1; m_mon++;
                  if (m_mon > 12) m_mon = 1;
               end
            end
         end
      end
   endtask

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      @(negedge clk); #1 sec_tick = 1'b1;
      repeat (n) @(negedge clk);
      #1 sec_tick = 1'b0;
      for (int i = 0; i < n; i++) model_tick();
   endtask

   task automatic do_clear();
      @(negedge clk); #1 host_clear = 1'b1;
      @(negedge clk); #1 host_clear = 1'b0;
   endtask

   task automatic post(input logic [NC-1:0] mask, input logic [15:0] dur);
      @(negedge clk); #1;
      for (int i = 0; i < NC; i++) if (mask[i]) cell_dur[i*16 +: 16] = dur;
      post_req = mask;
      @(negedge clk); #1 post_req = '0;
   endtask

   task automatic wait_served(input int target);
      int guard = 0;
      while (served < target && guard < 500) begin
         @(negedge clk);
         guard++;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic read_slot(input int a, output logic [RW-1:0] r);
      @(negedge clk); #1 rd_addr = CNT_W'(a);
      #1 r = rd_data;
   endtask

   function automatic logic [25:0] stamp_of(input int mo, input int d, input int h, input int mi, input int s);
      return {4'(mo), 5'(d), 5'(h), 6'(mi), 6'(s)};
   endfunction

   task automatic log_one(input int ch, input logic [15:0] dur, output logic [RW-1:0] r);
      int t;
      do_clear();
      t = served + 1;
      post(NC'(1) << ch, dur);
      wait_served(t);
      read_slot(0, r);
   endtask

   task automatic chk_stamp(input logic [RW-1:0] r, input string req, input logic [25:0] exp);
      chk(r[41:16] == exp, req, r[41:16], exp);
   endtask

   task automatic run_to_day_end(input int mo, input int d);
      int guard = 0;
      while (!(m_mon == mo && m_day == d && m_hr == HPD-1 && m_mi == MPH-1 && m_se == SPM-1) && guard < 6000) begin
         tick(1);
         guard++;
      end
   endtask

   task automatic t_reset();
      logic [RW-1:0] r;
      chk(entry_count == 0, "R1 count", entry_count, 0);
      chk(cell_ack == 0 && cell_clr == 0, "R1 strobes", {cell_ack, cell_clr}, 0);
      log_one(1, 16'h0001, r);
      chk_stamp(r, "R1 calendar start", stamp_of(1, 1, 0, 0, 0));
   endtask

   task automatic t_time_carry();
      logic [RW-1:0] r;
      tick(1);
      log_one(0, 16'h0002, r);
      chk_stamp(r, "R2 second step", stamp_of(1, 1, 0, 0, 1));
      tick(SPM - 1);
      log_one(0, 16'h0003, r);
      chk_stamp(r, "R2 minute carry", stamp_of(1, 1, 0, 1, 0));
      tick(SPM * (MPH - 1));
      log_one(0, 16'h0004, r);
      chk_stamp(r, "R2 hour carry", stamp_of(1, 1, 1, 0, 0));
      tick(SPM * MPH * (HPD - 1));
      log_one(0, 16'h0005, r);
      chk_stamp(r, "R2 day carry", stamp_of(1, 2, 0, 0, 0));
   endtask

   task automatic t_month_ends();
      logic [RW-1:0] r;
      run_to_day_end(1, 31);
      log_one(3, 16'h0010, r);
      chk_stamp(r, "R3 jan last", stamp_of(1, 31, HPD-1, MPH-1, SPM-1));
      tick(1);
      log_one(3, 16'h0011, r);
      chk_stamp(r, "R3 feb first", stamp_of(2, 1, 0, 0, 0));
      run_to_day_end(2, 28);
      tick(1);
      log_one(3, 16'h0012, r);
      chk_stamp(r, "R3 feb has 28 days", stamp_of(3, 1, 0, 0, 0));
      run_to_day_end(12, 31);
      log_one(2, 16'h0013, r);
      chk_stamp(r, "R3 dec last", stamp_of(12, 31, HPD-1, MPH-1, SPM-1));
      tick(1);
      log_one(2, 16'h0014, r);
      chk_stamp(r, "R3 year wrap", stamp_of(1, 1, 0, 0, 0));
   endtask

   task automatic t_capture();
      logic [RW-1:0] r;
      log_one(2, 16'hA5C3, r);
      chk(r[7:0] == 8'hC3, "R4 low byte", r[7:0], 8'hC3);
      chk(r[15:8] == 8'hA5, "R4 high byte", r[15:8], 8'hA5);
      chk(r[43:42] == 2'd2, "R4 channel", r[43:42], 2);
      chk_stamp(r, "R4 stamp", stamp_of(m_mon, m_day, m_hr, m_mi, m_se));
      chk(entry_count == 1, "R4 one entry", entry_count, 1);
   endtask

   task automatic t_handshake();
      chk(hs_err == 0, "R5 ack then clr one-hot", hs_err, 0);
      chk(cell_valid == 0, "R5 cells released", cell_valid, 0);
   endtask

   task automatic t_order();
      logic [RW-1:0] r0, r1, r2;
      int t, c0, c1, c2;
      do_clear();
      t = served + 3;
      post(4'b1011, 16'h3C3C);
      wait_served(t);
      chk(entry_count == 3, "R6 three entries", entry_count, 3);
      read_slot(0, r0); read_slot(1, r1); read_slot(2, r2);
      c0 = int'(r0[43:42]); c1 = int'(r1[43:42]); c2 = int'(r2[43:42]);
      chk(c0 != 2, "R6 first channel pending", c0, 0);
      chk(c1 == (c0 == 0 ? 1 : (c0 == 1 ? 3 : 0)), "R6 second in rotation", c1, c0);
      chk(c2 == (c1 == 0 ? 1 : (c1 == 1 ? 3 : 0)), "R6 third in rotation", c2, c1);
      chk(r2[15:0] == 16'h3C3C, "R6 duration kept", r2[15:0], 16'h3C3C);
   endtask

   task automatic t_idle();
      int a0 = ack_seen;
      logic [CNT_W-1:0] c0 = entry_count;
      repeat (30) @(negedge clk);
      chk(ack_seen == a0, "R9 no ack when idle", ack_seen, a0);
      chk(entry_count == c0, "R9 no entry when idle", entry_count, c0);
   endtask

   task automatic t_saturate();
      logic [RW-1:0] r;
      int t;
      do_clear();
      for (int k = 0; k < 5; k++) begin
         t = served + 1;
         post(4'b0010, 16'(16'h0100 + k));
         wait_served(t);
         chk(entry_count == ((k < DP-1) ? k + 1 : DP - 1), "R7 count", entry_count, (k < DP-1) ? k + 1 : DP - 1);
      end
      read_slot(DP - 1, r);
      chk(r[15:0] == 16'h0104, "R7 last slot overwritten", r[15:0], 16'h0104);
      read_slot(DP - 2, r);
      chk(r[15:0] == 16'h0102, "R7 earlier slot kept", r[15:0], 16'h0102);
   endtask

   task automatic t_clear();
      logic [RW-1:0] r;
      int t;
      tick(5);
      do_clear();
      chk(entry_count == 0, "R8 clear zeroes count", entry_count, 0);
      t = served + 1;
      post(4'b0001, 16'hBEEF);
      wait_served(t);
      chk(entry_count == 1, "R8 refill from slot 0", entry_count, 1);
      read_slot(0, r);
      chk(r[15:0] == 16'hBEEF, "R8 slot 0 data", r[15:0], 16'hBEEF);
      chk_stamp(r, "R8 calendar kept", stamp_of(m_mon, m_day, m_hr, m_mi, m_se));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_time_carry();
      t_capture();
      t_handshake();
      t_order();
      t_idle();
      t_saturate();
      t_handshake();
      t_clear();
      t_month_ends();
      t_handshake();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
   end

endmodule